// File: doc/BRIEF.md
# Static Memory Bank Access Controller

This block connects a processor-side read port to an external parallel memory bus that carries ROM, SRAM or flash parts behind six chip selects. Every bank is described by a 32-bit control word and a 2-bit width code, both driven as plain inputs. From the control word the block takes the bank's address window (a base pointer and a next pointer), the wait time of a first access, the shorter wait time of an access inside an open page, and the page size.

A request is decoded to the lowest-numbered bank whose window contains the address. The block then drives that bank's chip select, the beat address and output enable, and holds them for the programmed number of clocks. A 32-bit read on a 16-bit or 8-bit bank is split into two or four beats. The beats are assembled little-endian into the returned word. The chip select stays low after an access, which keeps the page open, so a later access to the same aligned page finishes in the page-access time.

Requests that decode to nothing usable end at once with an error. The width of bank 0 comes from two boot-size pins, so it is known before any control word has been set up.

Top module: `smem_ctrl`

## Requirements
- R1: A bank matches when address bits [25:16] are greater than or equal to its base pointer (control bits [19:10]) and less than its next pointer (control bits [29:20]). The pointers count in 64 KB units.
- R2: When several windows match, the lowest-numbered bank is used, and at most one chip select (active low) is ever asserted.
- R3: The access-cycle field (control bits [6:4]) codes 1 to 6 hold each first-access beat for 2 to 7 clocks, with address and output enable stable for that whole time.
- R4: Access-cycle codes 0 and 7 disable the bank, and a request to it ends with an error.
- R5: A request that matches no bank, or whose matching bank has width code 00, raises ready and error together one clock after it is sampled. No chip select and no output enable are asserted for it, and any open page is released.
- R6: Width code 01 means 8 bits, 10 means 16 bits and 11 means 32 bits. A word read takes 4, 2 or 1 beats at consecutive addresses starting at the word-aligned address. Beat k fills bytes from the low lanes of the bus upward (little-endian). Ready is a one-clock pulse raised after the last beat.
- R7: Bank 0 takes its width code from the boot-size pins. Its field in the width vector (bits [1:0]) has no effect.
- R8: The page-access field (control bits [3:2]) sets the clocks of a page-hit beat: 00 gives 5, 01 gives 2, 10 gives 3, 11 gives 4.
- R9: The page-mode field (control bits [1:0]) set to 00 turns off page hits. Codes 01, 10 and 11 give an aligned page of 4, 8 or 16 beats of the bank's width. A beat is a page hit only when it falls in the same page as the previous beat of the same bank while that bank's chip select has stayed asserted.
- R10: During reset and after it is released, all chip selects and output enable are high, and ready and error are low.
- R11: The reset-default bank 0 word 0x20000060 maps bank 0 from address 0 to just below 32 MB with 7-clock beats and no page hits.
- R12: After an access the bank's chip select stays low with output enable high. It is released only by an error, or moved by a request to another bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Read request, held until ready |
| req_addr | input | 26 | Byte address of the requested word |
| req_ready | output | 1 | One-clock completion pulse |
| req_rdata | output | 32 | Assembled read word, valid with ready |
| req_err | output | 1 | Error, valid with ready |
| bank_ctrl | input | 192 | Six 32-bit bank control words, bank 0 in the low bits |
| bank_width | input | 12 | Six 2-bit width codes, bank 0 in bits [1:0] (ignored) |
| boot_size | input | 2 | Width code for bank 0 |
| mem_cs_n | output | 6 | Active-low bank chip selects |
| mem_addr | output | 26 | Byte address of the current beat |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_rdata | input | 32 | Data from the memory, narrow parts on the low lanes |

## Verification
A wrong wait count shows up within the same beat: output enable or the beat address changes one clock early or late against the reference. A wrong page record is harder to see, because its effect appears only on a later request. There the first beat takes the first-access time instead of the page time, or the reverse, and that request's ready moves by several clocks. A mistake in lane placement or in the beat address step is invisible on the bus timing and shows only in the returned word at the ready pulse. A stale bank index shows as a wrong chip select while the bus is idle, on the first clock after the access.

// File: rtl/smem_pkg.sv
package smem_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BEAT = 2'd1,
    ST_DONE = 2'd2
  } smem_state_e;

  typedef struct packed {
    logic       usable;
    logic [2:0] first_cyc;
    logic [2:0] page_cyc;
    logic [1:0] pmode;
    logic [1:0] wcode;
  } bank_t;

  // First-access clocks: code 1..6 -> 2..7
  function automatic logic [2:0] first_cycles(input logic [2:0] code);
    return code + 3'd1;
  endfunction

  // Page-hit clocks: 00 -> 5, otherwise code + 1
  function automatic logic [2:0] page_cycles(input logic [1:0] code);
    return (code == 2'b00) ? 3'd5 : ({1'b0, code} + 3'd1);
  endfunction

  // Same aligned page: page spans (4 << (pmode-1)) beats of (1 << (wcode-1)) bytes
  function automatic logic same_page(input logic [31:0] a, input logic [31:0] b,
                                     input logic [1:0] pmode, input logic [1:0] wcode);
    logic [2:0]  sh;
    logic [31:0] mask;
    sh   = {1'b0, pmode} + {1'b0, wcode};
    mask = 32'hFFFF_FFFF << sh;
    return (pmode != 2'b00) && (((a ^ b) & mask) == 32'd0);
  endfunction

endpackage

// File: rtl/smem_bank_match.sv
module smem_bank_match
  import smem_pkg::*;
#(
  parameter int PTR_W = 10
) (
  input  logic [31:0]      ctrl_word,
  input  logic [1:0]       wcode,
  input  logic [PTR_W-1:0] addr_hi,
  output logic             hit,
  output bank_t            info
);

  localparam int PMODE_LSB = 0;
  localparam int PAGE_LSB  = 2;
  localparam int ACC_LSB   = 4;
  localparam int BASE_LSB  = 10;
  localparam int NEXT_LSB  = BASE_LSB + PTR_W;

  logic [PTR_W-1:0] base_ptr;
  logic [PTR_W-1:0] next_ptr;
  logic [2:0]       acc_code;
  logic             unused_ctrl;

  assign base_ptr = ctrl_word[BASE_LSB +: PTR_W];
  assign next_ptr = ctrl_word[NEXT_LSB +: PTR_W];
  assign acc_code = ctrl_word[ACC_LSB +: 3];

  assign hit = (addr_hi >= base_ptr) && (addr_hi < next_ptr);

  assign info.usable    = (acc_code != 3'd0) && (acc_code != 3'd7) && (wcode != 2'b00);
  assign info.first_cyc = first_cycles(acc_code);
  assign info.page_cyc  = page_cycles(ctrl_word[PAGE_LSB +: 2]);
  assign info.pmode     = ctrl_word[PMODE_LSB +: 2];
  assign info.wcode     = wcode;

  assign unused_ctrl = ^{ctrl_word[31:NEXT_LSB+PTR_W], ctrl_word[BASE_LSB-1:ACC_LSB+3]};

endmodule

// File: rtl/smem_bank_sel.sv
module smem_bank_sel
  import smem_pkg::*;
#(
  parameter  int NUM_BANKS = 6,
  parameter  int PTR_W     = 10,
  localparam int IDX_W     = $clog2(NUM_BANKS)
) (
  input  logic [NUM_BANKS*32-1:0] bank_ctrl,
  input  logic [NUM_BANKS*2-1:0]  bank_width,
  input  logic [1:0]              boot_size,
  input  logic [PTR_W-1:0]        addr_hi,
  output logic                    any_hit,
  output logic [IDX_W-1:0]        sel_idx,
  output bank_t                   sel_info
);

  logic [NUM_BANKS-1:0] match;
  bank_t                info [NUM_BANKS];
  logic                 unused_w0;

  assign unused_w0 = ^bank_width[1:0];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic [1:0] wc;
    if (g == 0) begin : g_boot
      assign wc = boot_size;
    end else begin : g_field
      assign wc = bank_width[g*2 +: 2];
    end
    smem_bank_match #(.PTR_W(PTR_W)) u_match (
      .ctrl_word (bank_ctrl[g*32 +: 32]),
      .wcode     (wc),
      .addr_hi   (addr_hi),
      .hit       (match[g]),
      .info      (info[g])
    );
  end

  // Lowest index wins: scan downward so the last hit assigned is the lowest
  always_comb begin
    any_hit  = 1'b0;
    sel_idx  = '0;
    sel_info = info[0];
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      if (match[b]) begin
        any_hit  = 1'b1;
        sel_idx  = IDX_W'(b);
        sel_info = info[b];
      end
    end
  end

endmodule

// File: rtl/smem_ctrl.sv
module smem_ctrl
  import smem_pkg::*;
#(
  parameter  int NUM_BANKS = 6,
  parameter  int ADDR_W    = 26,
  parameter  int PTR_W     = 10,
  localparam int IDX_W     = $clog2(NUM_BANKS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [ADDR_W-1:0]       req_addr,
  output logic                    req_ready,
  output logic [31:0]             req_rdata,
  output logic                    req_err,
  input  logic [NUM_BANKS*32-1:0] bank_ctrl,
  input  logic [NUM_BANKS*2-1:0]  bank_width,
  input  logic [1:0]              boot_size,
  output logic [NUM_BANKS-1:0]    mem_cs_n,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic                    mem_oe_n,
  input  logic [31:0]             mem_rdata
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // Decode
  logic             sel_hit;
  logic [IDX_W-1:0] sel_idx;
  bank_t            sel_info;

  smem_bank_sel #(.NUM_BANKS(NUM_BANKS), .PTR_W(PTR_W)) u_sel (
    .bank_ctrl  (bank_ctrl),
    .bank_width (bank_width),
    .boot_size  (boot_size),
    .addr_hi    (req_addr[ADDR_W-1 -: PTR_W]),
    .any_hit    (sel_hit),
    .sel_idx    (sel_idx),
    .sel_info   (sel_info)
  );

  // State
  smem_state_e          state_q, state_n;
  logic [2:0]           cnt_q, cnt_n;
  logic [1:0]           beat_q, beat_n;
  logic [NUM_BANKS-1:0] cs_n_q, cs_n_n;
  logic [ADDR_W-1:0]    addr_q, addr_n;
  logic                 oe_n_q, oe_n_n;
  logic [31:0]          rdata_q, rdata_n;
  logic                 rdy_q, rdy_n;
  logic                 err_q, err_n;
  logic                 open_q, open_n;
  logic [IDX_W-1:0]     idx_q, idx_n;
  bank_t                info_q, info_n;

  logic [ADDR_W-1:0] start_addr;
  logic [ADDR_W-1:0] next_addr;
  logic [1:0]        wlog;
  logic [1:0]        last_beat;
  logic              first_page_hit;
  logic              beat_page_hit;
  logic              unused_bits;

  assign unused_bits    = ^{req_addr[1:0], info_q.usable};
  assign start_addr     = {req_addr[ADDR_W-1:2], 2'b00};
  assign wlog           = info_q.wcode - 2'd1;
  assign last_beat      = 2'd3 >> wlog;
  assign next_addr      = addr_q + (ADDR_W'(1) << wlog);
  assign first_page_hit = open_q && (idx_q == sel_idx) &&
                          same_page(32'(start_addr), 32'(addr_q), sel_info.pmode, sel_info.wcode);
  assign beat_page_hit  = same_page(32'(next_addr), 32'(addr_q), info_q.pmode, info_q.wcode);

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    beat_n  = beat_q;
    cs_n_n  = cs_n_q;
    addr_n  = addr_q;
    oe_n_n  = oe_n_q;
    rdata_n = rdata_q;
    rdy_n   = rdy_q;
    err_n   = err_q;
    open_n  = open_q;
    idx_n   = idx_q;
    info_n  = info_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (!sel_hit || !sel_info.usable) begin
            err_n   = 1'b1;
            rdy_n   = 1'b1;
            cs_n_n  = '1;
            open_n  = 1'b0;
            state_n = ST_DONE;
          end else begin
            cnt_n   = (first_page_hit ? sel_info.page_cyc : sel_info.first_cyc) - 3'd1;
            cs_n_n  = ~(NUM_BANKS'(1) << sel_idx);
            addr_n  = start_addr;
            oe_n_n  = 1'b0;
            beat_n  = 2'd0;
            rdata_n = '0;
            info_n  = sel_info;
            idx_n   = sel_idx;
            open_n  = 1'b1;
            state_n = ST_BEAT;
          end
        end
      end
      ST_BEAT: begin
        if (cnt_q != 3'd0) begin
          cnt_n = cnt_q - 3'd1;
        end else begin
          for (int j = 0; j < 4; j++) begin
            if ((j >> wlog) == int'(beat_q))
              rdata_n[j*8 +: 8] = mem_rdata[(j & ((1 << wlog) - 1))*8 +: 8];
          end
          if (beat_q == last_beat) begin
            rdy_n   = 1'b1;
            oe_n_n  = 1'b1;
            state_n = ST_DONE;
          end else begin
            beat_n = beat_q + 2'd1;
            addr_n = next_addr;
            cnt_n  = (beat_page_hit ? info_q.page_cyc : info_q.first_cyc) - 3'd1;
          end
        end
      end
      default: begin
        rdy_n   = 1'b0;
        err_n   = 1'b0;
        state_n = ST_IDLE;
      end
    endcase
  end

  logic upd_en;
  assign upd_en = (state_q != ST_IDLE) || req_valid;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      beat_q  <= '0;
      cs_n_q  <= '1;
      addr_q  <= '0;
      oe_n_q  <= 1'b1;
      rdata_q <= '0;
      rdy_q   <= 1'b0;
      err_q   <= 1'b0;
      open_q  <= 1'b0;
      idx_q   <= '0;
      info_q  <= '0;
    end else if (upd_en) begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      beat_q  <= beat_n;
      cs_n_q  <= cs_n_n;
      addr_q  <= addr_n;
      oe_n_q  <= oe_n_n;
      rdata_q <= rdata_n;
      rdy_q   <= rdy_n;
      err_q   <= err_n;
      open_q  <= open_n;
      idx_q   <= idx_n;
      info_q  <= info_n;
    end
  end

  assign req_ready = rdy_q;
  assign req_err   = err_q;
  assign req_rdata = rdata_q;
  assign mem_cs_n  = cs_n_q;
  assign mem_addr  = addr_q;
  assign mem_oe_n  = oe_n_q;

  // Assertions
  assert_one_cs_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(~mem_cs_n));

  assert_err_quiet_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    req_err |-> (req_ready && (&mem_cs_n) && mem_oe_n));

  assert_ready_pulse_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    req_ready |=> !req_ready);

  assert_beat_hold_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_BEAT && cnt_q != 3'd0) |=> ($stable(mem_addr) && !mem_oe_n));

  assert_oe_needs_cs_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    !mem_oe_n |-> !(&mem_cs_n));

endmodule

// File: tb/smem_ctrl_tb.sv
module smem_ctrl_tb;

  logic         clk;
  logic         rst_n;
  logic         req_valid;
  logic [25:0]  req_addr;
  logic         req_ready;
  logic [31:0]  req_rdata;
  logic         req_err;
  logic [191:0] bank_ctrl;
  logic [11:0]  bank_width;
  logic [1:0]   boot_size;
  logic [5:0]   mem_cs_n;
  logic [25:0]  mem_addr;
  logic         mem_oe_n;
  logic [31:0]  mem_rdata;

  int checks = 0;
  int errors = 0;
  int open_b = -1;
  logic [25:0] open_a = '0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  smem_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .req_rdata(req_rdata), .req_err(req_err),
    .bank_ctrl(bank_ctrl), .bank_width(bank_width), .boot_size(boot_size),
    .mem_cs_n(mem_cs_n), .mem_addr(mem_addr), .mem_oe_n(mem_oe_n), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] mbyte(input logic [25:0] a);
    logic [31:0] x;
    x = 32'(a) * 32'd7 + (32'(a) >> 8) + (32'(a) >> 17);
    return x[7:0];
  endfunction

  // Memory model: byte at mem_addr+j on lane j
  always_comb begin
    for (int j = 0; j < 4; j++) mem_rdata[j*8 +: 8] = mbyte(mem_addr + 26'(j));
  end

  function automatic logic [31:0] mkctrl(input int base, input int nxt, input int acc,
                                         input int pc, input int pm);
    return (32'(nxt) << 20) | (32'(base) << 10) | (32'(acc) << 4) | (32'(pc) << 2) | 32'(pm);
  endfunction

  function automatic int ref_bank(input logic [25:0] a);
    for (int b = 0; b < 6; b++) begin
      logic [31:0] w;
      w = bank_ctrl[b*32 +: 32];
      if (a[25:16] >= w[19:10] && a[25:16] < w[29:20]) return b;
    end
    return -1;
  endfunction

  function automatic int ref_wcode(input int b);
    return (b == 0) ? int'(boot_size) : int'(bank_width[b*2 +: 2]);
  endfunction

  function automatic logic [5:0] cs_for(input int b);
    return (b < 0) ? 6'h3F : ~(6'b1 << b);
  endfunction

  function automatic bit ref_same(input logic [25:0] x, input logic [25:0] y,
                                  input int pm, input int wc);
    int sh;
    sh = pm + wc;
    return (pm != 0) && ((x >> sh) == (y >> sh));
  endfunction

  task automatic check_cyc(input string rq, input logic [5:0] ecs, input logic eoe,
                           input logic [25:0] eaddr, input bit chk_addr,
                           input logic erdy, input logic eerr);
    checks++;
    if (mem_cs_n !== ecs || mem_oe_n !== eoe || req_ready !== erdy || req_err !== eerr ||
        (chk_addr && mem_addr !== eaddr)) begin
      errors++;
      $display("FAIL %s t=%0t: cs=%b oe=%b addr=%h rdy=%b err=%b, expected cs=%b oe=%b addr=%h rdy=%b err=%b",
               rq, $time, mem_cs_n, mem_oe_n, mem_addr, req_ready, req_err,
               ecs, eoe, eaddr, erdy, eerr);
    end
  endtask

  // Drive one word read and compare every clock against the reference model
  task automatic do_read(input logic [25:0] a, input string rq);
    int b;
    logic [31:0] w;
    int wc, pm, fc, pc, nb, step;
    bit usable, hit;
    logic [25:0] cur, prev;
    logic [31:0] exp_data;
    b = ref_bank(a);
    usable = 1'b0;
    wc = 0; pm = 0; fc = 0; pc = 0;
    if (b >= 0) begin
      w  = bank_ctrl[b*32 +: 32];
      wc = ref_wcode(b);
      pm = int'(w[1:0]);
      fc = int'(w[6:4]) + 1;
      pc = (w[3:2] == 2'b00) ? 5 : int'(w[3:2]) + 1;
      usable = (w[6:4] >= 3'd1) && (w[6:4] <= 3'd6) && (wc != 0);
    end
    req_addr  = a;
    req_valid = 1'b1;
    @(negedge clk);
    if (!usable) begin
      check_cyc({rq, " error response (R5/R4)"}, 6'h3F, 1'b1, '0, 1'b0, 1'b1, 1'b1);
      open_b = -1;
      req_valid = 1'b0;
      @(negedge clk);
      check_cyc({rq, " after error (R5)"}, 6'h3F, 1'b1, '0, 1'b0, 1'b0, 1'b0);
    end else begin
      nb   = 4 >> (wc - 1);
      step = 1 << (wc - 1);
      cur  = {a[25:2], 2'b00};
      hit  = (open_b == b) && ref_same(cur, open_a, pm, wc);
      exp_data = {mbyte(cur + 26'd3), mbyte(cur + 26'd2), mbyte(cur + 26'd1), mbyte(cur)};
      open_b = b;
      for (int k = 0; k < nb; k++) begin
        int n;
        if (k > 0) begin
          prev = cur;
          cur  = cur + 26'(step);
          hit  = ref_same(cur, prev, pm, wc);
        end
        n = hit ? pc : fc;
        for (int c = 0; c < n; c++) begin
          check_cyc({rq, " beat timing (R1/R3/R8/R9)"}, cs_for(b), 1'b0, cur, 1'b1, 1'b0, 1'b0);
          @(negedge clk);
        end
      end
      open_a = cur;
      check_cyc({rq, " ready after last beat (R6)"}, cs_for(b), 1'b1, cur, 1'b1, 1'b1, 1'b0);
      checks++;
      if (req_rdata !== exp_data) begin
        errors++;
        $display("FAIL %s data (R6): got %h expected %h", rq, req_rdata, exp_data);
      end
      req_valid = 1'b0;
      @(negedge clk);
      check_cyc({rq, " idle hold (R12)"}, cs_for(b), 1'b1, cur, 1'b1, 1'b0, 1'b0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_addr  = '0;
    boot_size = 2'b10;
    bank_ctrl = '0;
    bank_ctrl[0*32 +: 32] = 32'h2000_0060;
    bank_ctrl[1*32 +: 32] = mkctrl(10'h200, 10'h220, 1, 2, 1);
    bank_ctrl[2*32 +: 32] = mkctrl(10'h220, 10'h240, 6, 0, 3);
    bank_ctrl[3*32 +: 32] = mkctrl(10'h240, 10'h260, 3, 1, 2);
    bank_ctrl[4*32 +: 32] = mkctrl(10'h250, 10'h280, 5, 0, 0);
    bank_ctrl[5*32 +: 32] = mkctrl(10'h280, 10'h290, 7, 0, 0);
    bank_width = {2'b01, 2'b11, 2'b10, 2'b11, 2'b01, 2'b11};

    repeat (3) @(negedge clk);
    check_cyc("R10 in reset", 6'h3F, 1'b1, '0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_cyc("R10 after reset", 6'h3F, 1'b1, '0, 1'b0, 1'b0, 1'b0);

    do_read(26'h000_0100, "R11 R7 bank0 default word, 16-bit boot width");
    do_read(26'h1FF_FFFC, "R1 bank0 top of window");
    do_read(26'h200_0000, "R1 bank1 base, 8-bit");
    do_read(26'h200_0000, "R9 bank1 same page again");
    do_read(26'h200_0004, "R9 bank1 next page");
    do_read(26'h220_0000, "R3 bank2 first access");
    do_read(26'h220_0004, "R8 bank2 page hit");
    do_read(26'h220_003C, "R8 bank2 page end");
    do_read(26'h220_0040, "R9 bank2 page crossed");
    do_read(26'h240_0000, "R6 bank3 16-bit");
    do_read(26'h250_0010, "R2 overlap picks bank3");
    do_read(26'h260_0000, "R12 move to bank4");
    do_read(26'h280_0000, "R4 bank5 code 7");
    do_read(26'h240_0008, "R12 page released by error");
    do_read(26'h290_0000, "R5 no bank");

    @(negedge clk);
    bank_ctrl[5*32 +: 32] = mkctrl(10'h280, 10'h290, 2, 0, 0);
    bank_width[11:10] = 2'b00;
    do_read(26'h280_0100, "R5 zero width bank");
    bank_width[11:10] = 2'b01;
    do_read(26'h280_0100, "R3 bank5 code 2, 8-bit");
    bank_ctrl[5*32 +: 32] = mkctrl(10'h280, 10'h290, 0, 0, 0);
    do_read(26'h280_0100, "R4 bank5 code 0");

    boot_size = 2'b01;
    do_read(26'h000_0200, "R7 bank0 boot 8-bit");
    boot_size = 2'b11;
    do_read(26'h000_0300, "R7 bank0 boot 32-bit");

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule